// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-driven management master for an external Ethernet PHY. Software puts one 16-bit command word into the control register. That word selects read or write and names a PHY address and a register number. For a write, software first loads the 16-bit data register. The engine then produces a standard Clause 22 management frame on the management clock and data lines. When a read finishes, the value returned by the PHY is placed in the data register. A sticky "finished" flag in the control register tells a polling driver when the next command may be issued.

The management clock is derived from the system clock by a parameterised divider. Its period is `2*HALF_DIV` system cycles. The clock stays low between commands. Outgoing data changes only on the falling clock edge. Incoming data is sampled on the rising edge.

The sequencer runs a state machine with five states:

- `ST_IDLE`: no command is active.
- `ST_PRE`: 32 preamble ones.
- `ST_HDR`: start code, opcode, PHY address and register number.
- `ST_TURN`: the two turnaround bits.
- `ST_DATA`: sixteen data bits.

The transitions are:

- `ST_IDLE` to `ST_PRE` on an accepted control write.
- `ST_PRE` to `ST_HDR` at the falling edge that closes bit 31.
- `ST_HDR` to `ST_TURN` after bit 45.
- `ST_TURN` to `ST_DATA` after bit 47.
- `ST_DATA` back to `ST_IDLE` after bit 63, which also sets the finished flag.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the control register reads 16'h4000 (finished bit 14 set, every other bit zero), the data register reads 0, the management clock is low and the data output enable is low.
- R2: A control write while finished is set starts a command. Bit 14 reads 0 from the next cycle. The register reads back only bit 13 (1 = write, 0 = read), PHY address bits 12:8 and register number bits 4:0. The written bits 15, 14 and 7:5 read as zero.
- R3: Every frame starts with 32 ones, then start code 01, then opcode 01 for a write or 10 for a read. The 5-bit PHY address follows, then the 5-bit register number, each sent MSB first.
- R4: A write frame sends turnaround 10 and then the 16 data-register bits, MSB first. The data register keeps its value.
- R5: A read frame drives the output enable high only for the first 46 bits, and low for the turnaround and data bits. The 16 bits sampled from the MDIO input on rising clock edges of bits 48..63 are placed in the data register MSB first.
- R6: The management clock period is 2*HALF_DIV system cycles. The MDIO output and its enable never change in the cycle the clock rises.
- R7: Bit 14 sets at the falling edge that ends bit 63. While it is set, the management clock is low and the output enable is low.
- R8: A control write while bit 14 is clear is ignored. The control readback and the running frame are unchanged.
- R9: A data-register write takes effect only while bit 14 is set. While a command runs it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| dat_wr | input | 1 | Write strobe for the data register |
| wdata | input | 16 | Write data for either register |
| ctl_rdata | output | 16 | Control readback: bit 14 finished, bit 13 write, 12:8 PHY, 4:0 register |
| dat_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Output enable for mdio_o (high = drive) |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
A wrong state or a bit counter that is off by one shows directly on the serial line. The frame then carries a shifted header, the output enable falls at the wrong bit, or the finished flag rises one or more clock periods early or late. All of these appear within the 64 management clocks of the frame in which the fault arises. A read-capture fault shows in the data register at the end of that same frame. A failure to hold the command fields or the data register during a busy write shows at the latest when the finished flag returns.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int LAST_PRE   = 31;
    localparam int LAST_HDR   = 45;
    localparam int LAST_TURN  = 47;
    localparam int LAST_DATA  = FRAME_BITS - 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } seq_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_write,
    input  logic [4:0]  phy,
    input  logic [4:0]  regn,
    input  logic [15:0] tx_word,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        busy,
    output logic        finish,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rx_word
);
    seq_state_t            state, state_nx;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [IDX_W-1:0]      bit_idx;
    logic                  wr_op;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_PRE;
            ST_PRE:  if (fall_evt && bit_idx == IDX_W'(LAST_PRE))  state_nx = ST_HDR;
            ST_HDR:  if (fall_evt && bit_idx == IDX_W'(LAST_HDR))  state_nx = ST_TURN;
            ST_TURN: if (fall_evt && bit_idx == IDX_W'(LAST_TURN)) state_nx = ST_DATA;
            ST_DATA: if (fall_evt && bit_idx == IDX_W'(LAST_DATA)) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath: frame shifter, bit counter, read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '1;
            bit_idx <= '0;
            wr_op   <= 1'b0;
            rx_word <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                tx_sh   <= {32'hFFFF_FFFF, 2'b01,
                            is_write ? 2'b01 : 2'b10, phy, regn,
                            is_write ? {2'b10, tx_word} : 18'h3FFFF};
                bit_idx <= '0;
                wr_op   <= is_write;
            end
        end else begin
            if (fall_evt) begin
                tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b1};
                bit_idx <= bit_idx + 1'b1;
            end
            if (rise_evt && state == ST_DATA && !wr_op)
                rx_word <= {rx_word[14:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        finish  = (state == ST_DATA) && fall_evt && (bit_idx == IDX_W'(LAST_DATA));
        unique case (state)
            ST_PRE, ST_HDR:   mdio_oe = 1'b1;
            ST_TURN, ST_DATA: mdio_oe = wr_op;
            default:          mdio_oe = 1'b0;
        endcase
        mdio_o = mdio_oe ? tx_sh[FRAME_BITS-1] : 1'b1;
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic        dat_wr,
    input  logic [15:0] wdata,
    output logic [15:0] ctl_rdata,
    output logic [15:0] dat_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        done_q, op_w_q;
    logic [4:0]  phy_q, reg_q;
    logic [15:0] data_q, rx_word;
    logic        accept, busy, finish, rise_evt, fall_evt;

    assign accept = ctl_wr && done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
            op_w_q <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                done_q <= 1'b0;
                op_w_q <= wdata[13];
                phy_q  <= wdata[12:8];
                reg_q  <= wdata[4:0];
            end else if (finish) begin
                done_q <= 1'b1;
                if (!op_w_q) data_q <= rx_word;
            end
            if (dat_wr && done_q) data_q <= wdata;
        end
    end

    assign ctl_rdata = {1'b0, done_q, op_w_q, phy_q, 3'b000, reg_q};
    assign dat_rdata = data_q;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_write (wdata[13]),
        .phy      (wdata[12:8]),
        .regn     (wdata[4:0]),
        .tx_word  (data_q),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .finish   (finish),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rx_word  (rx_word)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr,
    input logic        dat_wr,
    input logic [15:0] ctl_rdata,
    input logic [15:0] dat_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_rdata[14]) |=> !ctl_rdata[14]);

    assert_busy_ctl_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_rdata[14]) |=> $stable(ctl_rdata[13:0]));

    assert_busy_dat_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !ctl_rdata[14]) |=> ($stable(dat_rdata) || ctl_rdata[14]));

    assert_mdio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[14] |-> (!mdc && !mdio_oe));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .dat_wr    (dat_wr),
    .ctl_rdata (ctl_rdata),
    .dat_rdata (dat_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_cmd_engine.sv
`timescale 1ns/1ps
module tb_mdio_cmd_engine;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, dat_wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] ctl_rdata, dat_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mdio_cmd_engine #(.HALF_DIV(H)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .dat_wr(dat_wr),
        .wdata(wdata), .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // {write, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [26:0] VEC [6] = '{
        {1'b1, 5'h01, 5'h00, 16'h1140},
        {1'b0, 5'h1F, 5'h1F, 16'h8001},
        {1'b1, 5'h00, 5'h00, 16'h0000},
        {1'b0, 5'h15, 5'h0A, 16'hA55A},
        {1'b1, 5'h1F, 5'h1F, 16'hFFFF},
        {1'b0, 5'h00, 5'h01, 16'h0000}
    };

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk); ctl_wr = 1'b1; wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [15:0] v);
        @(negedge clk); dat_wr = 1'b1; wdata = v;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] d, input logic inject);
        logic [63:0] got, oe_got, exp, exp_oe;
        logic [15:0] exp_ctl;
        time t0, t1;
        int wait_cyc;
        if (wr) begin
            wr_dat(d);
            chk(dat_rdata == d, "R9 idle data write", 64'(dat_rdata), 64'(d));
        end
        exp_ctl = {2'b00, wr, phy, 3'b000, rg};
        mdio_i = 1'b1;
        wr_ctl({2'b11, wr, phy, 3'b111, rg});
        chk(ctl_rdata == exp_ctl, "R2 busy readback masked", 64'(ctl_rdata), 64'(exp_ctl));
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            got[63-k]    = mdio_o;
            oe_got[63-k] = mdio_oe;
            if (k == 0) t0 = $time;
            if (k == 1) t1 = $time;
            if (!wr && k >= 47 && k < 63) begin
                #1 mdio_i = d[62-k];
            end
            if (inject && k == 20) begin
                wr_ctl(16'h2A5A ^ {1'b0, wr, 14'h0});
                wr_dat(16'h1234);
            end
        end
        wait_cyc = 0;
        while (!ctl_rdata[14] && wait_cyc < 4*H) begin
            @(negedge clk); wait_cyc++;
        end
        mdio_i = 1'b1;
        exp    = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg, wr ? {2'b10, d} : 18'h0};
        exp_oe = wr ? '1 : {{46{1'b1}}, 18'h0};
        chk(t1 - t0 == 64'(2*H*10), "R6 mdc period", 64'(t1 - t0), 64'(2*H*10));
        chk(got[63:18] == exp[63:18], "R3 header bits", 64'(got[63:18]), 64'(exp[63:18]));
        chk(oe_got == exp_oe, "R5 output enable pattern", oe_got, exp_oe);
        if (wr) chk(got[17:0] == exp[17:0], "R4 turnaround and data", 64'(got[17:0]), 64'(exp[17:0]));
        chk(ctl_rdata[14] && wait_cyc <= 2*H, "R7 finished timing", 64'(wait_cyc), 64'(2*H));
        chk(dat_rdata == d, wr ? "R9 data kept" : "R5 read capture", 64'(dat_rdata), 64'(d));
        chk(ctl_rdata == (exp_ctl | 16'h4000), "R8 fields after command", 64'(ctl_rdata), 64'(exp_ctl | 16'h4000));
        chk(!mdc && !mdio_oe, "R7 line idle", {62'h0, mdc, mdio_oe}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rdata == 16'h4000, "R1 control reset", 64'(ctl_rdata), 64'h4000);
        chk(dat_rdata == 16'h0, "R1 data reset", 64'(dat_rdata), 64'h0);
        chk(!mdc && !mdio_oe, "R1 line reset", {62'h0, mdc, mdio_oe}, 64'h0);

        for (int i = 0; i < 6; i++)
            run_txn(VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);

        // R8 / R9: writes during a running command are ignored
        run_txn(1'b1, 5'h0C, 5'h13, 16'h3C96, 1'b1);
        run_txn(1'b0, 5'h06, 5'h11, 16'h5AC3, 1'b1);

        // R9: idle data write lands after a read
        wr_dat(16'hBEEF);
        chk(dat_rdata == 16'hBEEF, "R9 idle write after read", 64'(dat_rdata), 64'hBEEF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule